// File: doc/BRIEF.md
# Four-Channel Parallel-Bus Converter Sequencer

This block is the digital front end of a four-channel, 12-bit successive-approximation sampling converter that sits on a parallel microprocessor-style bus. The host controls it through three active-low strobes: chip select, write and read. Pulling write low while chip select is low starts a conversion. The rising edge of write, or of read, latches a 2-bit channel address.

During a conversion the block holds its busy output low. It steps through one acquire window, twelve compare steps and a finish window, 16 clock periods in all. In each compare step it presents a trial code to an external comparator and reads back one decision bit. When busy rises, the result sits in the output register. The host reads it by taking chip select and read low, which raises the output-enable signal that stands in for the bus drivers.

The analog mux, sample stage, trial DAC and comparator are outside the block. The block drives `chan` and `trial` to them and receives `cmp_hi`, which is high when the sampled input is at or above the trial code.

Top module: `adc_par_seq`

## Requirements
- R1: A conversion starts at the first clock edge where `cs_n` and `wr_n` are both sampled low after not both being low, provided the block is idle. `busy_n` is low from the next cycle on, and `dout_oe` is low for as long as `busy_n` is low.
- R2: A rising edge of `wr_n` or of `rd_n`, seen while `cs_n` is low, copies `addr` into `chan`. Encoding: `chan` value 0, 1, 2 and 3 select analog inputs 0, 1, 2 and 3.
- R3: Once a conversion has passed its 2-cycle acquire window, address strobes leave `chan` unchanged until `busy_n` rises.
- R4: `busy_n` stays low for exactly 16 consecutive clock cycles per conversion.
- R5: In the first compare cycle (the third cycle of `busy_n` low), `trial` is 12'h800. The final result equals the largest 12-bit code not above the comparator threshold, found MSB (bit 11) first to LSB (bit 0).
- R6: `dout` changes only at the clock edge where `busy_n` rises, and then takes the new result.
- R7: `dout_oe` is high exactly when `cs_n` and `rd_n` are both low, `busy_n` is high, and at least one conversion has completed since reset.
- R8: A new start strobe while `busy_n` is low is ignored. The running conversion keeps its length, channel and result.
- R9: After reset, `busy_n` is 1, `dout_oe` is 0, `chan` is 0, `trial` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; 16 periods per conversion |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; starts a conversion and latches the address on its rise |
| rd_n | input | 1 | Read strobe, active low; gates the result onto the bus and latches the address on its rise |
| addr | input | 2 | Channel address |
| cmp_hi | input | 1 | Comparator decision: sampled input is at or above `trial` |
| chan | output | 2 | Latched channel selection to the analog mux |
| trial | output | 12 | Trial code to the DAC/comparator |
| busy_n | output | 1 | Low while a conversion runs |
| dout | output | 12 | Conversion result |
| dout_oe | output | 1 | Output enable for the data bus drivers |

## Verification
A behavioural comparator in the bench answers from a per-channel target code. Random targets show whether every SAR bit decision lands correctly. The directed targets 0, 4095, 2048 and 2047 are the codes where a wrong comparison sense or a missed MSB or LSB step gives away a wrong answer. Some conversions carry a second start strobe, a late address strobe and a read attempt while busy. These separate a sequencer that really ignores them from one that restarts, changes channel or enables the bus. Read-only address strobes while idle, and reads before any conversion, check the capture path and the output-enable qualification.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_SAR  = 2'd2,
    PH_FIN  = 2'd3
  } conv_phase_e;

  // bit position decided in a given step count of the conversion
  function automatic int sar_pos(input int step, input int acq, input int dw);
    return dw - 1 - (step - acq);
  endfunction

  // phase for a given step count, when active
  function automatic conv_phase_e phase_of(input bit active, input int step,
                                           input int acq, input int dw);
    if (!active)          return PH_IDLE;
    if (step < acq)       return PH_ACQ;
    if (step < acq + dw)  return PH_SAR;
    return PH_FIN;
  endfunction

endpackage

// File: rtl/adc_strobe_dec.sv
module adc_strobe_dec #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cap_allow,
  output logic              start_req,
  output logic [ADDR_W-1:0] chan
);

  logic wr_q, rd_q, both_lo_q;
  logic both_lo, wr_rise, rd_rise, cap_evt;

  assign both_lo   = ~cs_n & ~wr_n;
  assign start_req = both_lo & ~both_lo_q;
  assign wr_rise   = ~wr_q & wr_n;
  assign rd_rise   = ~rd_q & rd_n;
  assign cap_evt   = (wr_rise | rd_rise) & ~cs_n & cap_allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b1;
      rd_q      <= 1'b1;
      both_lo_q <= 1'b0;
      chan      <= '0;
    end else begin
      wr_q      <= wr_n;
      rd_q      <= rd_n;
      both_lo_q <= both_lo;
      if (cap_evt) chan <= addr;
    end
  end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int ACQ_CYC = 2,
  parameter int DATA_W  = 12,
  parameter int FIN_CYC = 2,
  localparam int TOTAL  = ACQ_CYC + DATA_W + FIN_CYC,
  localparam int CNT_W  = $clog2(TOTAL),
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             active,
  output conv_phase_e      phase,
  output logic [IDX_W-1:0] bit_idx,
  output logic             done
);

  logic [CNT_W-1:0] step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        step   <= '0;
      end
    end else if (done) begin
      active <= 1'b0;
      step   <= '0;
    end else begin
      step <= step + 1'b1;
    end
  end

  assign done    = active && (int'(step) == TOTAL - 1);
  assign phase   = phase_of(active, int'(step), ACQ_CYC, DATA_W);
  assign bit_idx = IDX_W'(sar_pos(int'(step), ACQ_CYC, DATA_W));

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int DATA_W = 12,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step_en,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              cmp_hi,
  input  logic              load,
  output logic [DATA_W-1:0] trial,
  output logic [DATA_W-1:0] result,
  output logic              have_result
);

  logic [DATA_W-1:0] acc;

  function automatic logic [DATA_W-1:0] with_bit(input logic [DATA_W-1:0] v,
                                                 input logic [IDX_W-1:0] i);
    logic [DATA_W-1:0] r;
    r    = v;
    r[i] = 1'b1;
    return r;
  endfunction

  assign trial = step_en ? with_bit(acc, bit_idx) : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc         <= '0;
      result      <= '0;
      have_result <= 1'b0;
    end else begin
      if (clear)                 acc <= '0;
      else if (step_en && cmp_hi) acc <= trial;
      if (load) begin
        result      <= acc;
        have_result <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_par_seq.sv
module adc_par_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int ADDR_W  = 2,
  parameter int ACQ_CYC = 2,
  parameter int FIN_CYC = 2,
  localparam int TOTAL  = ACQ_CYC + DATA_W + FIN_CYC,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cmp_hi,
  output logic [ADDR_W-1:0] chan,
  output logic [DATA_W-1:0] trial,
  output logic              busy_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  logic             start_req, start_evt, active, done, conv_late, have_result;
  conv_phase_e      phase;
  logic [IDX_W-1:0] bit_idx;

  assign start_evt = start_req & ~active;
  assign conv_late = (phase == PH_SAR) || (phase == PH_FIN);

  adc_strobe_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .addr      (addr),
    .cap_allow (~conv_late),
    .start_req (start_req),
    .chan      (chan)
  );

  adc_conv_timer #(.ACQ_CYC(ACQ_CYC), .DATA_W(DATA_W), .FIN_CYC(FIN_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_evt),
    .active  (active),
    .phase   (phase),
    .bit_idx (bit_idx),
    .done    (done)
  );

  adc_sar_core #(.DATA_W(DATA_W)) u_sar (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start_evt),
    .step_en     (phase == PH_SAR),
    .bit_idx     (bit_idx),
    .cmp_hi      (cmp_hi),
    .load        (done),
    .trial       (trial),
    .result      (dout),
    .have_result (have_result)
  );

  assign busy_n  = ~active;
  assign dout_oe = have_result & ~active & ~cs_n & ~rd_n;

endmodule

// File: rtl/adc_par_seq_chk.sv
module adc_par_seq_chk #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 2,
  parameter int TOTAL  = 16,
  localparam int LEN_W = $clog2(TOTAL) + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              busy_n,
  input logic              dout_oe,
  input logic [ADDR_W-1:0] chan,
  input logic [DATA_W-1:0] dout,
  input logic              start_evt,
  input logic              conv_late
);

  logic [LEN_W-1:0] lo_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lo_len <= '0;
    else if (!busy_n) lo_len <= lo_len + 1'b1;
    else              lo_len <= '0;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !busy_n); // R1
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (int'(lo_len) == TOTAL)); // R4
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> (int'(lo_len) < TOTAL)); // R4
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_late |=> $stable(chan)); // R3
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |=> $stable(dout)); // R6
  AST_OE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !dout_oe); // R7
  AST_OE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (!cs_n && !rd_n)); // R7

endmodule

bind adc_par_seq adc_par_seq_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .TOTAL  (ACQ_CYC + DATA_W + FIN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .busy_n    (busy_n),
  .dout_oe   (dout_oe),
  .chan      (chan),
  .dout      (dout),
  .start_evt (start_evt),
  .conv_late (conv_late)
);

// File: tb/test_adc_par_seq.sv
module test_adc_par_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic        cmp_hi;
  logic [1:0]  chan;
  logic [11:0] trial, dout;
  logic        busy_n, dout_oe;
  logic [11:0] tgt [4];
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  adc_par_seq i_adc_par_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .cmp_hi(cmp_hi), .chan(chan), .trial(trial),
    .busy_n(busy_n), .dout(dout), .dout_oe(dout_oe)
  );

  // behavioural comparator: input at or above trial code
  always_comb cmp_hi = (tgt[chan] >= trial);

  // expected SAR answer, restated as a bit-serial search
  function automatic logic [11:0] exp_code(input logic [11:0] thr);
    logic [11:0] a = '0;
    for (int b = 11; b >= 0; b--) begin
      logic [11:0] t = a | (12'd1 << b);
      if (thr >= t) a = t;
    end
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [1:0] ch, input logic [11:0] code, input bit intrude);
    int lo;
    logic [11:0] prev = dout;
    tgt[ch] = code;
    @(negedge clk); addr = ch; cs_n = 0; wr_n = 0;
    @(negedge clk);
    chk(busy_n == 0, "R1 busy low", busy_n, 0);
    wr_n = 1;
    lo = 1;
    forever begin
      @(negedge clk);
      if (busy_n) break;
      lo++;
      if (lo == 2) begin
        cs_n = 1;
        chk(chan == ch, "R2 chan", chan, ch);
      end
      if (lo == 3) chk(trial == 12'h800, "R5 first trial", trial, 12'h800);
      if (lo == 4) chk(dout == prev, "R6 dout held", dout, prev);
      if (intrude && lo == 5) begin
        addr = ch ^ 2'd3; cs_n = 0; wr_n = 0; rd_n = 0;
        #1 chk(dout_oe == 0, "R7 oe while busy", dout_oe, 0);
      end
      if (intrude && lo == 6) begin wr_n = 1; rd_n = 1; end
      if (intrude && lo == 7) begin
        cs_n = 1; addr = ch;
        chk(chan == ch, "R3 late capture blocked", chan, ch);
      end
      if (lo > 40) break;
    end
    chk(lo == 16, intrude ? "R8 busy length" : "R4 busy length", lo, 16);
    chk(dout == exp_code(code), intrude ? "R8 result" : "R5 result", dout, exp_code(code));
    chk(dout_oe == 0, "R7 oe no strobe", dout_oe, 0);
    cs_n = 0; rd_n = 0;
    #1 chk(dout_oe == 1, "R7 oe read", dout_oe, 1);
    @(negedge clk); rd_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 4; i++) tgt[i] = '0;
    #23 rst_n = 1;
    @(negedge clk);
    chk(busy_n == 1, "R9 busy_n", busy_n, 1);
    chk(chan == 0, "R9 chan", chan, 0);
    chk(trial == 0, "R9 trial", trial, 0);
    chk(dout == 0, "R9 dout", dout, 0);
    cs_n = 0; rd_n = 0;
    #1 chk(dout_oe == 0, "R7 no result yet", dout_oe, 0);
    @(negedge clk); rd_n = 1;
    @(negedge clk); cs_n = 1;

    run_conv(2'd0, 12'h000, 0);
    run_conv(2'd1, 12'hFFF, 0);
    run_conv(2'd2, 12'h800, 1);
    run_conv(2'd3, 12'h7FF, 1);
    run_conv(2'd1, 12'h001, 0);

    // read strobe rise captures address while idle
    @(negedge clk); addr = 2'd2; cs_n = 0; rd_n = 0;
    @(negedge clk); rd_n = 1;
    @(negedge clk); cs_n = 1;
    chk(chan == 2'd2, "R2 rd capture", chan, 2);
    // strobe rise without chip select is ignored
    @(negedge clk); addr = 2'd1; rd_n = 0;
    @(negedge clk); rd_n = 1;
    @(negedge clk);
    chk(chan == 2'd2, "R2 no cs", chan, 2);

    for (int n = 0; n < 40; n++) begin
      run_conv(2'($urandom_range(0, 3)), 12'($urandom_range(0, 4095)),
               bit'($urandom_range(0, 1)));
    end
    summary();
  end

endmodule